// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block moves whole data words safely between two unrelated clock domains. A producer on the write clock offers one word at a time by raising a valid flag next to the data. The word is stored unless the queue is full, and the full indication lives entirely in the write domain. A consumer on the read clock always sees the oldest stored word on its data output, with no read latency. It removes that word by raising a read request, and it watches an empty indication that lives entirely in the read domain.

Storage is a small array of 2**ADDR_W words. It is written on the write clock and read combinationally at the read address, so the head word is visible as soon as the empty flag drops. Each side keeps a binary pointer one bit wider than the address, plus a Gray-coded copy of it. The Gray copy is the only thing that crosses to the other domain, through a chain of two flip-flops. Full and empty are registered, and both are computed from the pointer value that follows the current clock edge. Each domain has its own synchronous, active-low reset.

Top module: `cdcf_fifo`

## Requirements
- R1: The queue holds exactly 2**ADDR_W words (ADDR_W at least 2). Starting from empty with no reads, wr_full stays 0 after each of the first 2**ADDR_W-1 accepted writes and reads 1 after the 2**ADDR_W-th, sampled after that write's clock edge.
- R2: A word is stored on a rising wr_clk edge only when wr_vld is 1 and wr_full is 0. With wr_vld at 0, nothing is stored.
- R3: A write offered while wr_full is 1 is dropped. The write pointer does not move, and the dropped word never appears at the read side.
- R4: While rd_empty is 0, rd_data shows the oldest stored word without any read request, and it holds that word until it is removed.
- R5: A read request on a rising rd_clk edge with rd_empty at 0 removes the head word. After the last stored word is removed, rd_empty reads 1 following that edge.
- R6: A read request while rd_empty is 1 is ignored. The read pointer does not move, and the next word written is the next word delivered.
- R7: While wr_rst_n is 0 at a wr_clk edge, wr_full becomes 0 after that edge. While rd_rst_n is 0 at a rd_clk edge, rd_empty becomes 1 after that edge.
- R8: With unrelated write and read clock periods, every accepted word is delivered exactly once and in write order. The pointers crossing domains are Gray coded and change by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous reset, active low |
| wr_vld | input | 1 | Word on wr_data is offered this cycle |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Queue full; offered words are dropped |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous reset, active low |
| rd_req | input | 1 | Remove the head word at this edge |
| rd_data | output | DATA_W | Oldest stored word; undefined while empty |
| rd_empty | output | 1 | Queue empty as seen from the read domain |

## Verification
Two pairs of operations can land in the same cycle here. A write can arrive at the edge where the queue turns full, and a read can arrive at the edge where it turns empty. In the streaming phase a write and a read also take place on overlapping edges of the two clocks while the queue sits near either limit. This is provoked by running a 10 ns write clock against a 13 ns read clock. The reader is stalled in periodic windows so the queue fills, and the writer keeps offering a marker word while full, so dropped offers meet concurrent removals. The result is judged only at the ports: each removed word must equal the next value of an arithmetic sequence, the total must match the writes accepted, and the flags must settle to empty and not full at the end.

// File: rtl/cdcf_pkg.sv
package cdcf_pkg;
  // number of flip-flops each pointer passes through when it changes domain
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/cdcf_sync.sv
module cdcf_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  import cdcf_pkg::*;

  logic [W-1:0] stg_q [SYNC_STAGES];
  logic [W-1:0] stg_n [SYNC_STAGES];

  always_comb begin
    stg_n[0] = d;
    for (int i = 1; i < int'(SYNC_STAGES); i++) begin
      stg_n[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(SYNC_STAGES); i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < int'(SYNC_STAGES); i++) stg_q[i] <= stg_n[i];
    end
  end

  assign q = stg_q[SYNC_STAGES-1];
endmodule

// File: rtl/cdcf_mem.sv
module cdcf_mem #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cell_q[waddr] <= wdata;
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/cdcf_wr_ctl.sv
module cdcf_wr_ctl #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray,
  output logic              full
);
  logic [ADDR_W:0] wbin_q, wbin_n;
  logic [ADDR_W:0] wgray_q, wgray_n;
  logic            full_q, full_n;
  logic [ADDR_W:0] full_pat;

  always_comb begin
    we       = vld & ~full_q;
    wbin_n   = wbin_q + {{ADDR_W{1'b0}}, we};
    wgray_n  = wbin_n ^ (wbin_n >> 1);
    full_pat = {~rgray_sync[ADDR_W:ADDR_W-1], rgray_sync[ADDR_W-2:0]};
    full_n   = (wgray_n == full_pat);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
    end else begin
      wbin_q  <= wbin_n;
      wgray_q <= wgray_n;
      full_q  <= full_n;
    end
  end

  assign waddr = wbin_q[ADDR_W-1:0];
  assign wgray = wgray_q;
  assign full  = full_q;

  // R3: an offer while full leaves the write pointer where it was
  assert_wr_hold_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && full_q) |=> (wbin_q == $past(wbin_q)));

  // R8: the crossing Gray pointer flips at most one bit per edge
  assert_wgray_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);

  // R7: reset clears the full flag
  assert_wr_reset_R7: assert property (@(posedge clk)
    (!rst_n) |=> !full_q);
endmodule

// File: rtl/cdcf_rd_ctl.sv
module cdcf_rd_ctl #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W:0]   wgray_sync,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray,
  output logic              empty
);
  logic [ADDR_W:0] rbin_q, rbin_n;
  logic [ADDR_W:0] rgray_q, rgray_n;
  logic            empty_q, empty_n;
  logic            re;

  always_comb begin
    re      = req & ~empty_q;
    rbin_n  = rbin_q + {{ADDR_W{1'b0}}, re};
    rgray_n = rbin_n ^ (rbin_n >> 1);
    empty_n = (rgray_n == wgray_sync);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
    end else begin
      rbin_q  <= rbin_n;
      rgray_q <= rgray_n;
      empty_q <= empty_n;
    end
  end

  assign raddr = rbin_q[ADDR_W-1:0];
  assign rgray = rgray_q;
  assign empty = empty_q;

  // R6: a request while empty leaves the read pointer where it was
  assert_rd_hold_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && empty_q) |=> (rbin_q == $past(rbin_q)));

  // R8: the crossing Gray pointer flips at most one bit per edge
  assert_rgray_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);

  // R7: reset sets the empty flag
  assert_rd_reset_R7: assert property (@(posedge clk)
    (!rst_n) |=> empty_q);
endmodule

// File: rtl/cdcf_fifo.sv
module cdcf_fifo #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_vld,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  localparam int unsigned PTR_W = ADDR_W + 1;

  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wgray, rgray;
  logic [PTR_W-1:0]  wgray_in_rd, rgray_in_wr;

  initial begin
    if (ADDR_W < 2) $error("ADDR_W must be at least 2");
  end

  cdcf_wr_ctl #(.ADDR_W(ADDR_W)) wr_ctl_i (
    .clk        (wr_clk),
    .rst_n      (wr_rst_n),
    .vld        (wr_vld),
    .rgray_sync (rgray_in_wr),
    .we         (we),
    .waddr      (waddr),
    .wgray      (wgray),
    .full       (wr_full)
  );

  cdcf_rd_ctl #(.ADDR_W(ADDR_W)) rd_ctl_i (
    .clk        (rd_clk),
    .rst_n      (rd_rst_n),
    .req        (rd_req),
    .wgray_sync (wgray_in_rd),
    .raddr      (raddr),
    .rgray      (rgray),
    .empty      (rd_empty)
  );

  cdcf_sync #(.W(PTR_W)) w2r_sync_i (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     (wgray),
    .q     (wgray_in_rd)
  );

  cdcf_sync #(.W(PTR_W)) r2w_sync_i (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .d     (rgray),
    .q     (rgray_in_wr)
  );

  cdcf_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
    .wclk  (wr_clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (rd_data)
  );
endmodule

// File: tb/cdcf_fifo_tb.sv
`timescale 1ns/1ps
module cdcf_fifo_tb_top;
  localparam int AW     = 3;
  localparam int DW     = 8;
  localparam int DEPTH  = 1 << AW;
  localparam int STREAM = 400;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n, rd_rst_n;
  logic wr_vld, rd_req;
  logic [DW-1:0] wr_data, rd_data;
  logic wr_full, rd_empty;

  int errors = 0, checks = 0;
  int n_wr = 0, n_rd = 0;
  bit done = 0;

  always #5   wr_clk = ~wr_clk;
  always #6.5 rd_clk = ~rd_clk;

  cdcf_fifo #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_vld(wr_vld), .wr_data(wr_data),
    .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_req(rd_req),
    .rd_data(rd_data), .rd_empty(rd_empty)
  );

  function automatic logic [DW-1:0] seq(int k);
    return DW'((k * 29 + 3) & 255);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // pop every available word until n_rd reaches target; checks order
  task automatic drain_to(int target, string tag);
    while (n_rd < target) begin
      @(negedge rd_clk);
      if (!rd_empty) begin
        chk(rd_data == seq(n_rd), tag, rd_data, seq(n_rd));
        rd_req = 1'b1;
        n_rd++;
      end else rd_req = 1'b0;
    end
    @(negedge rd_clk);
    rd_req = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_rd, n_wr);
    finish_run();
  end

  initial begin
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    wr_vld = 1'b0; rd_req = 1'b0; wr_data = '0;
    repeat (4) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
    // R7: flags in reset
    chk(rd_empty == 1'b1, "R7 empty in reset", rd_empty, 1);
    @(negedge wr_clk);
    chk(wr_full == 1'b0, "R7 full in reset", wr_full, 0);
    wr_rst_n = 1'b1;
    @(negedge rd_clk);
    rd_rst_n = 1'b1;
    repeat (3) @(negedge wr_clk);

    // R1, R2: fill from empty with no reads
    wr_vld = 1'b0;
    @(negedge wr_clk);
    chk(wr_full == 1'b0, "R2 idle keeps not full", wr_full, 0);
    for (int k = 1; k <= DEPTH; k++) begin
      wr_vld = 1'b1; wr_data = seq(n_wr); n_wr++;
      @(negedge wr_clk);
      chk(wr_full == (k == DEPTH), "R1 full after fill count", wr_full, int'(k == DEPTH));
    end
    // R3: offers while full are dropped
    for (int k = 0; k < 4; k++) begin
      wr_vld = 1'b1; wr_data = 8'hA5;
      @(negedge wr_clk);
      chk(wr_full == 1'b1, "R3 stays full", wr_full, 1);
    end
    wr_vld = 1'b0;

    // R4: head visible without a request and held
    while (rd_empty) @(negedge rd_clk);
    for (int k = 0; k < 5; k++) begin
      chk(rd_data == seq(0), "R4 head shown without request", rd_data, seq(0));
      @(negedge rd_clk);
    end
    // R5, R3: drain in order; no dropped word appears
    drain_to(DEPTH, "R3 R5 drain order");
    chk(rd_empty == 1'b1, "R5 empty after last pop", rd_empty, 1);
    repeat (6) @(negedge wr_clk);
    chk(wr_full == 1'b0, "R5 full released after drain", wr_full, 0);

    // R6: requests while empty are ignored
    rd_req = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge rd_clk);
      chk(rd_empty == 1'b1, "R6 empty under request", rd_empty, 1);
    end
    rd_req = 1'b0;
    @(negedge wr_clk);
    wr_vld = 1'b1; wr_data = seq(n_wr); n_wr++;
    @(negedge wr_clk);
    wr_vld = 1'b0;
    while (rd_empty) @(negedge rd_clk);
    chk(rd_data == seq(n_rd), "R6 next word after ignored reads", rd_data, seq(n_rd));
    drain_to(n_wr, "R6 single word");
    chk(rd_empty == 1'b1, "R6 empty again", rd_empty, 1);

    // R8: concurrent stream with unrelated clocks
    fork
      begin : writer
        int cyc = 0;
        int stop = n_wr + STREAM;
        while (n_wr < stop) begin
          @(negedge wr_clk);
          cyc++;
          if (wr_full) begin
            wr_vld = 1'b1; wr_data = 8'h5A;
          end else if ((cyc % 7) != 3) begin
            wr_vld = 1'b1; wr_data = seq(n_wr); n_wr++;
          end else wr_vld = 1'b0;
        end
        @(negedge wr_clk);
        wr_vld = 1'b0;
        done = 1;
      end
      begin : reader
        int cyc = 0;
        while (!(done && n_rd == n_wr)) begin
          @(negedge rd_clk);
          cyc++;
          if (!rd_empty && ((cyc % 64) < 40) && ((cyc % 3) != 0)) begin
            chk(rd_data == seq(n_rd), "R8 stream order", rd_data, seq(n_rd));
            rd_req = 1'b1; n_rd++;
          end else rd_req = 1'b0;
        end
        @(negedge rd_clk);
        rd_req = 1'b0;
      end
    join
    repeat (6) @(negedge rd_clk);
    chk(n_rd == n_wr, "R8 word count", n_rd, n_wr);
    chk(rd_empty == 1'b1, "R8 empty at end", rd_empty, 1);
    @(negedge wr_clk);
    chk(wr_full == 1'b0, "R8 not full at end", wr_full, 0);
    finish_run();
  end
endmodule